// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block runs linked chains of transfer descriptors kept in memory, on behalf of a small set of DMA channels. Software loads a channel's descriptor pointer with the address of the first descriptor. It then raises that channel's start bit through a masked command write. The walker serves one chain at a time. It reads the five words of a descriptor through a single-outstanding word-read port and hands the captured control word, addresses and count to an external data mover. It waits for the mover's completion pulse, then either fetches the next descriptor or ends the chain.

A chain ends in one of four ways: a descriptor arrives with its link flag clear, the mover reports an early end of transfer, the mover reports an error, or software halts it. On each end the walker drops the start bit and its active indication. An interrupt pulse is raised only when the enable for that kind of ending is set in the final descriptor. A read error during a fetch, or a mover error, sets the channel's sticky error flag. The pointer register always holds the descriptor being executed, so software can locate where a chain stopped.

Top module: `sg_chain_engine`

## Requirements
- R1: After synchronous reset, all start bits, active bits, error flags and interrupt pulses are 0, and neither a memory read nor a mover launch is requested.
- R2: On a command write, the start bit of channel i takes the value of `cmd_go[i]` only when `cmd_sel[i]` is 1. Unselected channels keep their start bits.
- R3: A descriptor is fetched as five word reads at pointer+0, +4, +8, +12 and +16. Each read's request and address are held until its `mem_rd_valid`. `mv_start` pulses for one cycle, in the cycle after the fifth word is accepted.
- R4: While `mv_start` is high, `mv_ctrl`, `mv_src` and `mv_dst` carry words 0, 1 and 2, `mv_count` carries bits 15:0 of word 3, and `mv_chan` names the served channel.
- R5: When the mover completes without early end or error, and bit 31 (link) of word 3 is set, the walker fetches next from the address in word 4.
- R6: When a chain ends normally or by early end of transfer, the start and active bits clear one cycle after `mv_done`. `irq` for that channel pulses in that same cycle only if bit 29 (normal end) or bit 28 (early end) of word 3 is set.
- R7: A mover error ends the chain, sets the channel's error flag and clears its start bit. It pulses `irq` only if bit 27 of word 3 is set.
- R8: A read error during a fetch sets the error flag, clears the start bit, ends the chain without launching the mover, and raises no interrupt.
- R9: A channel whose start bit is cleared by software stops at its next read return or mover completion. It issues no further reads, launches nothing and raises no interrupt.
- R10: A pointer write loads the selected channel's pointer. Each link step replaces the served channel's pointer with the next address, so after a chain ends the pointer names its last executed descriptor.
- R11: When several start bits are set while the walker is idle, the lowest-numbered channel is served first. The others wait with their start bits set and active bits clear.
- R12: `sg_active` has at most one bit set: the served channel's, from its grant until its chain ends.
- R13: A command write that sets a channel's start bit also clears that channel's error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_go | input | NCH | Start-bit values for the write |
| cmd_sel | input | NCH | Per-channel write enables for the start bits |
| ptr_we | input | 1 | Descriptor pointer write strobe |
| ptr_sel | input | CHW | Channel whose pointer is written |
| ptr_wdata | input | 32 | New descriptor address |
| start_q | output | NCH | Start bits |
| sg_active | output | NCH | Channel currently owned by the walker |
| err_flag | output | NCH | Sticky per-channel error flags |
| irq | output | NCH | One-cycle interrupt pulses |
| desc_ptr | output | NCH*32 | Per-channel descriptor pointers, channel 0 in the low word |
| mem_rd_req | output | 1 | Word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |
| mem_rd_err | input | 1 | Read failed, qualified by valid |
| mv_start | output | 1 | Launch pulse to the data mover |
| mv_chan | output | CHW | Channel of the launched transfer |
| mv_ctrl | output | 32 | Descriptor control word |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_count | output | 16 | Transfer count in bus-width units |
| mv_done | input | 1 | Mover completion pulse |
| mv_eot | input | 1 | Completion was an early end of transfer |
| mv_err | input | 1 | Completion was an error |

## Verification
On every cycle the assertions check the following. At most one channel is active. A pending read keeps its request and address until data returns. A mover launch is a single pulse that directly follows a returned word. Interrupts appear only right after a mover completion. An error flag rises only after a read error or a mover error. The following can only be shown by the bench's scenarios, which compare every cycle against a behavioural model:
- the masked command write;
- the five-word fetch order and the fields handed to the mover;
- chain following through the link flag;
- choosing among the three interrupt enables;
- priority among simultaneously started channels;
- halting a self-linked chain;
- error clearing on restart.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DESC_WORDS = 5;
    localparam int IDX_W      = 3;

    // positions inside the control-and-count word
    localparam int LINK_BIT   = 31;
    localparam int IE_TC_BIT  = 29;
    localparam int IE_EOT_BIT = 28;
    localparam int IE_ERR_BIT = 27;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_FETCH  = 2'd1,
        W_LAUNCH = 2'd2,
        W_WAIT   = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic              link;
        logic              ie_tc;
        logic              ie_eot;
        logic              ie_err;
        logic [CNT_W-1:0]  count;
        logic [WORD_W-1:0] next;
    } desc_t;

    // which interrupt enable applies to the way a descriptor finished
    function automatic logic end_irq(input desc_t d, input logic eot, input logic err);
        if (err)
            return d.ie_err;
        else if (eot)
            return d.ie_eot;
        else
            return d.ie_tc;
    endfunction

    function automatic logic [WORD_W-1:0] word_offset(input logic [IDX_W-1:0] idx);
        return {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
    endfunction

endpackage

// File: rtl/sgc_cmd_reg.sv
module sgc_cmd_reg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_we,
    input  logic [NCH-1:0] cmd_go,
    input  logic [NCH-1:0] cmd_sel,
    input  logic [NCH-1:0] eng_clr,
    input  logic [NCH-1:0] err_set,
    output logic [NCH-1:0] start_q,
    output logic [NCH-1:0] err_q
);

    logic [NCH-1:0] wr_hit;
    logic [NCH-1:0] wr_launch;

    assign wr_hit    = {NCH{cmd_we}} & cmd_sel;
    assign wr_launch = wr_hit & cmd_go;

    // software write wins over the engine's clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            err_q   <= '0;
        end else begin
            start_q <= (wr_hit & cmd_go) | (~wr_hit & start_q & ~eng_clr);
            err_q   <= ~wr_launch & (err_q | err_set);
        end
    end

endmodule

// File: rtl/sgc_pick.sv
module sgc_pick #(
    parameter  int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i])
                idx = CHW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/sgc_walker.sv
module sgc_walker
    import sgc_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    start_q,
    input  logic              pick_any,
    input  logic [CHW-1:0]    pick_idx,
    input  logic [WORD_W-1:0] cur_ptr,
    output logic [CHW-1:0]    cur_ch,
    output logic              busy,
    output logic [NCH-1:0]    eng_clr,
    output logic [NCH-1:0]    err_set,
    output logic [NCH-1:0]    irq,
    output logic              ptr_load,
    output logic [WORD_W-1:0] ptr_load_val,
    output logic              mem_rd_req,
    output logic [WORD_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    input  logic              mem_rd_err,
    output logic              mv_start,
    output logic [WORD_W-1:0] mv_ctrl,
    output logic [WORD_W-1:0] mv_src,
    output logic [WORD_W-1:0] mv_dst,
    output logic [CNT_W-1:0]  mv_count,
    input  logic              mv_done,
    input  logic              mv_eot,
    input  logic              mv_err
);

    walk_state_e      st_q, st_d;
    logic [CHW-1:0]   ch_q, ch_d;
    logic [IDX_W-1:0] widx_q, widx_d;
    desc_t            d_q;
    logic [NCH-1:0]   irq_q, irq_d;

    logic cur_started;
    logic clr_ch, errs, adv, irq_fire, take_word;

    assign cur_started = start_q[ch_q];
    assign take_word   = (st_q == W_FETCH) && mem_rd_valid && !mem_rd_err;

    always_comb begin
        st_d     = st_q;
        ch_d     = ch_q;
        widx_d   = widx_q;
        clr_ch   = 1'b0;
        errs     = 1'b0;
        adv      = 1'b0;
        irq_fire = 1'b0;
        unique case (st_q)
            W_IDLE: begin
                if (pick_any) begin
                    st_d   = W_FETCH;
                    ch_d   = pick_idx;
                    widx_d = '0;
                end
            end
            W_FETCH: begin
                if (mem_rd_valid) begin
                    if (mem_rd_err) begin
                        errs   = 1'b1;
                        clr_ch = 1'b1;
                        st_d   = W_IDLE;
                    end else if (!cur_started) begin
                        st_d = W_IDLE;
                    end else if (widx_q == IDX_W'(DESC_WORDS - 1)) begin
                        st_d = W_LAUNCH;
                    end else begin
                        widx_d = widx_q + 1'b1;
                    end
                end
            end
            W_LAUNCH: begin
                st_d = W_WAIT;
            end
            W_WAIT: begin
                if (mv_done) begin
                    if (mv_err) begin
                        errs     = 1'b1;
                        clr_ch   = 1'b1;
                        irq_fire = end_irq(d_q, mv_eot, mv_err);
                        st_d     = W_IDLE;
                    end else if (!cur_started) begin
                        st_d = W_IDLE;
                    end else if (mv_eot || !d_q.link) begin
                        clr_ch   = 1'b1;
                        irq_fire = end_irq(d_q, mv_eot, mv_err);
                        st_d     = W_IDLE;
                    end else begin
                        adv    = 1'b1;
                        st_d   = W_FETCH;
                        widx_d = '0;
                    end
                end
            end
            default: st_d = W_IDLE;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            eng_clr[i] = clr_ch   && (ch_q == CHW'(i));
            err_set[i] = errs     && (ch_q == CHW'(i));
            irq_d[i]   = irq_fire && (ch_q == CHW'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= W_IDLE;
            ch_q   <= '0;
            widx_q <= '0;
            d_q    <= '0;
            irq_q  <= '0;
        end else begin
            st_q   <= st_d;
            ch_q   <= ch_d;
            widx_q <= widx_d;
            irq_q  <= irq_d;
            if (take_word) begin
                unique case (widx_q)
                    3'd0: d_q.ctrl <= mem_rd_data;
                    3'd1: d_q.src  <= mem_rd_data;
                    3'd2: d_q.dst  <= mem_rd_data;
                    3'd3: begin
                        d_q.link   <= mem_rd_data[LINK_BIT];
                        d_q.ie_tc  <= mem_rd_data[IE_TC_BIT];
                        d_q.ie_eot <= mem_rd_data[IE_EOT_BIT];
                        d_q.ie_err <= mem_rd_data[IE_ERR_BIT];
                        d_q.count  <= mem_rd_data[CNT_W-1:0];
                    end
                    default: d_q.next <= mem_rd_data;
                endcase
            end
        end
    end

    assign cur_ch       = ch_q;
    assign busy         = (st_q != W_IDLE);
    assign irq          = irq_q;
    assign ptr_load     = adv;
    assign ptr_load_val = d_q.next;
    assign mem_rd_req   = (st_q == W_FETCH);
    assign mem_rd_addr  = cur_ptr + word_offset(widx_q);
    assign mv_start     = (st_q == W_LAUNCH);
    assign mv_ctrl      = d_q.ctrl;
    assign mv_src       = d_q.src;
    assign mv_dst       = d_q.dst;
    assign mv_count     = d_q.count;

endmodule

// File: rtl/sg_chain_engine.sv
module sg_chain_engine
    import sgc_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_we,
    input  logic [NCH-1:0]        cmd_go,
    input  logic [NCH-1:0]        cmd_sel,
    input  logic                  ptr_we,
    input  logic [CHW-1:0]        ptr_sel,
    input  logic [WORD_W-1:0]     ptr_wdata,
    output logic [NCH-1:0]        start_q,
    output logic [NCH-1:0]        sg_active,
    output logic [NCH-1:0]        err_flag,
    output logic [NCH-1:0]        irq,
    output logic [NCH*WORD_W-1:0] desc_ptr,
    output logic                  mem_rd_req,
    output logic [WORD_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [WORD_W-1:0]     mem_rd_data,
    input  logic                  mem_rd_err,
    output logic                  mv_start,
    output logic [CHW-1:0]        mv_chan,
    output logic [WORD_W-1:0]     mv_ctrl,
    output logic [WORD_W-1:0]     mv_src,
    output logic [WORD_W-1:0]     mv_dst,
    output logic [CNT_W-1:0]      mv_count,
    input  logic                  mv_done,
    input  logic                  mv_eot,
    input  logic                  mv_err
);

    logic [NCH-1:0]    eng_clr, err_set;
    logic              pick_any;
    logic [CHW-1:0]    pick_idx, cur_ch;
    logic              busy, ptr_load;
    logic [WORD_W-1:0] ptr_load_val, cur_ptr;
    logic [WORD_W-1:0] ptr_arr [NCH];

    sgc_cmd_reg #(.NCH(NCH)) cmd_i (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (cmd_we),
        .cmd_go  (cmd_go),
        .cmd_sel (cmd_sel),
        .eng_clr (eng_clr),
        .err_set (err_set),
        .start_q (start_q),
        .err_q   (err_flag)
    );

    sgc_pick #(.NCH(NCH)) pick_i (
        .req (start_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ptr
            logic [WORD_W-1:0] ptr_r;
            always_ff @(posedge clk) begin
                if (rst)
                    ptr_r <= '0;
                else if (ptr_load && (cur_ch == CHW'(c)))
                    ptr_r <= ptr_load_val;
                else if (ptr_we && (ptr_sel == CHW'(c)))
                    ptr_r <= ptr_wdata;
            end
            assign ptr_arr[c]                    = ptr_r;
            assign desc_ptr[c*WORD_W +: WORD_W]  = ptr_r;
            assign sg_active[c]                  = busy && (cur_ch == CHW'(c));
        end
    endgenerate

    assign cur_ptr = ptr_arr[cur_ch];
    assign mv_chan = cur_ch;

    sgc_walker #(.NCH(NCH)) walk_i (
        .clk          (clk),
        .rst          (rst),
        .start_q      (start_q),
        .pick_any     (pick_any),
        .pick_idx     (pick_idx),
        .cur_ptr      (cur_ptr),
        .cur_ch       (cur_ch),
        .busy         (busy),
        .eng_clr      (eng_clr),
        .err_set      (err_set),
        .irq          (irq),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_err   (mem_rd_err),
        .mv_start     (mv_start),
        .mv_ctrl      (mv_ctrl),
        .mv_src       (mv_src),
        .mv_dst       (mv_dst),
        .mv_count     (mv_count),
        .mv_done      (mv_done),
        .mv_eot       (mv_eot),
        .mv_err       (mv_err)
    );

endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] sg_active,
    input logic [NCH-1:0] err_flag,
    input logic [NCH-1:0] irq,
    input logic           mem_rd_req,
    input logic [31:0]    mem_rd_addr,
    input logic           mem_rd_valid,
    input logic           mem_rd_err,
    input logic           mv_start,
    input logic           mv_done,
    input logic           mv_err
);

    // R12: at most one channel owned
    a_r12_single_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sg_active));

    // R3: an unanswered read keeps request and address
    a_r3_read_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R3: launch follows directly on a returned word
    a_r3_launch_after_word: assert property (@(posedge clk) disable iff (rst)
        mv_start |-> $past(mem_rd_valid));

    // R4: launch is one cycle wide
    a_r4_launch_pulse: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);

    // R6: interrupts only right after a mover completion
    a_r6_irq_after_done: assert property (@(posedge clk) disable iff (rst)
        (|irq) |-> $past(mv_done));

    // R8: error flags rise only after a read or mover error
    a_r8_err_source: assert property (@(posedge clk) disable iff (rst)
        (|(err_flag & ~$past(err_flag))) |->
            ($past(mv_done && mv_err) || $past(mem_rd_valid && mem_rd_err)));

endmodule

bind sg_chain_engine sgc_checker #(.NCH(NCH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .sg_active    (sg_active),
    .err_flag     (err_flag),
    .irq          (irq),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_err   (mem_rd_err),
    .mv_start     (mv_start),
    .mv_done      (mv_done),
    .mv_err       (mv_err)
);

// File: tb/sg_chain_engine_tb_top.sv
module sg_chain_engine_tb_top;

    localparam int NCH = 4;
    localparam int CHW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              cmd_we = 0;
    logic [NCH-1:0]    cmd_go = '0, cmd_sel = '0;
    logic              ptr_we = 0;
    logic [CHW-1:0]    ptr_sel = '0;
    logic [31:0]       ptr_wdata = '0;
    logic [NCH-1:0]    start_q, sg_active, err_flag, irq;
    logic [NCH*32-1:0] desc_ptr;
    logic              mem_rd_req;
    logic [31:0]       mem_rd_addr;
    logic              mem_rd_valid = 0;
    logic [31:0]       mem_rd_data = '0;
    logic              mem_rd_err = 0;
    logic              mv_start;
    logic [CHW-1:0]    mv_chan;
    logic [31:0]       mv_ctrl, mv_src, mv_dst;
    logic [15:0]       mv_count;
    logic              mv_done = 0, mv_eot = 0, mv_err = 0;

    sg_chain_engine #(.NCH(NCH)) dut_i (.*);

    int compared = 0, mismatched = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- memory and mover responders ----------------
    logic [31:0] mem [int unsigned];
    logic [31:0] bad_addr = 32'hFFFF_FFF0;
    int mv_kind = 0;   // 0 normal, 1 early end, 2 error
    int mv_cnt = 0;
    int launches = 0;
    int irq_cnt [NCH];

    always @(negedge clk) begin
        if (mem_rd_req && !mem_rd_valid) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
            mem_rd_err   <= (mem_rd_addr == bad_addr);
        end else begin
            mem_rd_valid <= 1'b0;
            mem_rd_err   <= 1'b0;
        end
        mv_done <= (mv_cnt == 1);
        mv_eot  <= (mv_cnt == 1) && (mv_kind == 1);
        mv_err  <= (mv_cnt == 1) && (mv_kind == 2);
        if (mv_cnt > 0) mv_cnt <= mv_cnt - 1;
        if (mv_start && !rst) begin
            mv_cnt <= 3;
            launches++;
        end
        for (int i = 0; i < NCH; i++)
            if (irq[i] && !rst) irq_cnt[i]++;
    end

    // ---------------- behavioural reference model ----------------
    int          m_state = 0, m_ch = 0, m_idx = 0;
    logic [31:0] m_w [5];
    logic [NCH-1:0] m_start = '0, m_err = '0, m_irq = '0;
    logic [31:0] m_ptr [NCH];

    always @(posedge clk) begin
        logic [NCH-1:0] clr;
        logic [NCH-1:0] eset;
        bit adv;
        clr = '0; eset = '0; adv = 0;
        if (rst) begin
            m_state = 0; m_ch = 0; m_idx = 0; m_start = '0; m_err = '0; m_irq = '0;
            for (int i = 0; i < NCH; i++) m_ptr[i] = '0;
            for (int i = 0; i < 5; i++) m_w[i] = '0;
        end else begin
            m_irq = '0;
            case (m_state)
                0: begin
                    for (int i = NCH - 1; i >= 0; i--)
                        if (m_start[i]) begin m_ch = i; m_state = 1; m_idx = 0; end
                end
                1: if (mem_rd_valid) begin
                    if (mem_rd_err) begin
                        eset[m_ch] = 1; clr[m_ch] = 1; m_state = 0;
                    end else if (!m_start[m_ch]) begin
                        m_state = 0;
                    end else begin
                        m_w[m_idx] = mem_rd_data;
                        if (m_idx == 4) m_state = 2; else m_idx++;
                    end
                end
                2: m_state = 3;
                default: if (mv_done) begin
                    if (mv_err) begin
                        eset[m_ch] = 1; clr[m_ch] = 1; m_state = 0;
                        m_irq[m_ch] = m_w[3][27];
                    end else if (!m_start[m_ch]) begin
                        m_state = 0;
                    end else if (mv_eot) begin
                        clr[m_ch] = 1; m_state = 0; m_irq[m_ch] = m_w[3][28];
                    end else if (m_w[3][31]) begin
                        adv = 1; m_state = 1; m_idx = 0;
                    end else begin
                        clr[m_ch] = 1; m_state = 0; m_irq[m_ch] = m_w[3][29];
                    end
                end
            endcase
            if (ptr_we) m_ptr[ptr_sel] = ptr_wdata;
            if (adv) m_ptr[m_ch] = m_w[4];
            m_start = m_start & ~clr;
            m_err   = m_err | eset;
            if (cmd_we)
                for (int i = 0; i < NCH; i++)
                    if (cmd_sel[i]) begin
                        m_start[i] = cmd_go[i];
                        if (cmd_go[i]) m_err[i] = 1'b0;
                    end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [NCH-1:0] exp_act;
            exp_act = (m_state != 0) ? (NCH'(1) << m_ch) : '0;
            check(start_q == m_start, "R2", "start bits", 32'(start_q), 32'(m_start));
            check(sg_active == exp_act, "R12", "active bits", 32'(sg_active), 32'(exp_act));
            check(err_flag == m_err, "R8", "error flags", 32'(err_flag), 32'(m_err));
            check(irq == m_irq, "R6", "irq", 32'(irq), 32'(m_irq));
            check(mem_rd_req == (m_state == 1), "R3", "read request", 32'(mem_rd_req), 32'(m_state == 1));
            if (m_state == 1)
                check(mem_rd_addr == m_ptr[m_ch] + 32'(4 * m_idx), "R3", "read address",
                      mem_rd_addr, m_ptr[m_ch] + 32'(4 * m_idx));
            check(mv_start == (m_state == 2), "R3", "launch", 32'(mv_start), 32'(m_state == 2));
            if (m_state == 2) begin
                check(mv_ctrl == m_w[0], "R4", "ctrl", mv_ctrl, m_w[0]);
                check(mv_src == m_w[1], "R4", "src", mv_src, m_w[1]);
                check(mv_dst == m_w[2], "R4", "dst", mv_dst, m_w[2]);
                check(mv_count == m_w[3][15:0], "R4", "count", 32'(mv_count), 32'(m_w[3][15:0]));
                check(mv_chan == CHW'(m_ch), "R4", "chan", 32'(mv_chan), 32'(m_ch));
            end
            for (int i = 0; i < NCH; i++)
                check(desc_ptr[i*32 +: 32] == m_ptr[i], "R10", "pointer", desc_ptr[i*32 +: 32], m_ptr[i]);
        end
    end

    // ---------------- helpers ----------------
    task automatic put_desc(input logic [31:0] a, input logic [31:0] cc, input logic [31:0] nxt);
        mem[a]      = 32'hC000_0000 | a;
        mem[a + 4]  = 32'h1000_0000 + a;
        mem[a + 8]  = 32'h2000_0000 + a;
        mem[a + 12] = cc;
        mem[a + 16] = nxt;
    endtask

    task automatic set_ptr(input int ch, input logic [31:0] a);
        @(negedge clk); ptr_we = 1; ptr_sel = CHW'(ch); ptr_wdata = a;
        @(negedge clk); ptr_we = 0;
    endtask

    task automatic command(input logic [NCH-1:0] go, input logic [NCH-1:0] sel);
        @(negedge clk); cmd_we = 1; cmd_go = go; cmd_sel = sel;
        @(negedge clk); cmd_we = 0; cmd_go = '0; cmd_sel = '0;
    endtask

    task automatic wait_quiet();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (start_q == '0 && sg_active == '0 && mv_cnt == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        int l0;
        for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(start_q == 0 && sg_active == 0, "R1", "start/active after reset", 32'({start_q, sg_active}), 0);
        check(err_flag == 0 && irq == 0, "R1", "err/irq after reset", 32'({err_flag, irq}), 0);
        check(!mem_rd_req && !mv_start, "R1", "req/launch after reset", 32'({mem_rd_req, mv_start}), 0);

        // R2: unselected write changes nothing
        command(4'hF, 4'h0);
        repeat (3) @(negedge clk);
        check(start_q == 0 && !mem_rd_req, "R2", "write without enables", 32'(start_q), 0);

        // R3 R4 R5 R10 R6: three-descriptor chain on channel 0
        put_desc(32'h100, 32'h8000_0008, 32'h120);
        put_desc(32'h120, 32'h8000_0010, 32'h140);
        put_desc(32'h140, 32'h2000_0004, 32'h0);
        set_ptr(0, 32'h100);
        command(4'h1, 4'h1);
        wait_quiet();
        check(desc_ptr[31:0] == 32'h140, "R5", "pointer after chain", desc_ptr[31:0], 32'h140);
        check(launches == 3, "R4", "launches in chain", 32'(launches), 3);
        check(irq_cnt[0] == 1, "R6", "final normal irq", 32'(irq_cnt[0]), 1);

        // R6: early end with and without its enable
        mv_kind = 1;
        put_desc(32'h200, 32'h9000_0002, 32'h220);
        set_ptr(1, 32'h200);
        command(4'h2, 4'h2);
        wait_quiet();
        check(irq_cnt[1] == 1, "R6", "early end irq enabled", 32'(irq_cnt[1]), 1);
        put_desc(32'h240, 32'hA000_0002, 32'h260);
        set_ptr(1, 32'h240);
        command(4'h2, 4'h2);
        wait_quiet();
        check(irq_cnt[1] == 1, "R6", "early end irq disabled", 32'(irq_cnt[1]), 1);

        // R7: mover error stops a linked chain
        mv_kind = 2;
        l0 = launches;
        put_desc(32'h300, 32'h8800_0001, 32'h320);
        put_desc(32'h320, 32'h2000_0001, 32'h0);
        set_ptr(2, 32'h300);
        command(4'h4, 4'h4);
        wait_quiet();
        check(err_flag[2] == 1'b1, "R7", "error flag after mover error", 32'(err_flag), 32'h4);
        check(launches == l0 + 1, "R7", "no launch after error", 32'(launches), 32'(l0 + 1));
        check(irq_cnt[2] == 1, "R7", "error irq", 32'(irq_cnt[2]), 1);

        // R13: restart clears error
        mv_kind = 0;
        set_ptr(2, 32'h320);
        command(4'h4, 4'h4);
        wait_quiet();
        check(err_flag[2] == 1'b0, "R13", "error cleared by restart", 32'(err_flag), 0);

        // R8: read error in the second descriptor of a chain
        l0 = launches;
        put_desc(32'h400, 32'hA000_0003, 32'h420);
        put_desc(32'h420, 32'h2800_0003, 32'h0);
        bad_addr = 32'h428;
        set_ptr(3, 32'h400);
        command(4'h8, 4'h8);
        wait_quiet();
        check(err_flag[3] == 1'b1 && start_q[3] == 1'b0, "R8", "read error flag", 32'({err_flag, start_q}), 32'h80);
        check(launches == l0 + 1, "R8", "no launch for bad descriptor", 32'(launches), 32'(l0 + 1));
        check(irq_cnt[3] == 0, "R8", "no irq on read error", 32'(irq_cnt[3]), 0);
        bad_addr = 32'hFFFF_FFF0;

        // R11: two channels started together
        set_ptr(1, 32'h140);
        set_ptr(3, 32'h140);
        command(4'hA, 4'hA);
        for (int k = 0; k < 10 && sg_active == 0; k++) @(negedge clk);
        check(sg_active == 4'h2 && start_q[3], "R11", "lower channel served first", 32'({sg_active, start_q}), 32'h2A);
        wait_quiet();
        check(irq_cnt[1] == 2 && irq_cnt[3] == 1, "R11", "both chains ran", 32'({irq_cnt[1][15:0], irq_cnt[3][15:0]}), 32'h0002_0001);

        // R9: halt a self-linked chain
        put_desc(32'h600, 32'hE000_0001, 32'h600);
        set_ptr(0, 32'h600);
        command(4'h1, 4'h1);
        repeat (60) @(negedge clk);
        command(4'h0, 4'h1);
        wait_quiet();
        l0 = launches;
        repeat (30) @(negedge clk);
        check(launches == l0 && !mem_rd_req, "R9", "halted chain idle", 32'(launches), 32'(l0));
        check(irq_cnt[0] == 1, "R9", "no irq on halt", 32'(irq_cnt[0]), 1);
        check(desc_ptr[31:0] == 32'h600, "R10", "pointer holds halted descriptor", desc_ptr[31:0], 32'h600);

        finish_run();
    end

endmodule